// File: doc/BRIEF.md
# Flow-Through Burst SRAM

This block is a small synchronous single-port memory. Its read path is flow-through: data for the current word appears combinationally after the clock edge, with no output register. Every access belongs to a burst of up to four words. A burst opens when one of two address strobes is raised. One strobe comes from the processor side and one from the controller side. The block then captures the address and the chip enable. Later words of the burst come from a 2-bit beat counter. The counter moves only when the step input is high. A static order pin chooses linear or interleaved beat order.

Writes are byte-granular. Each data lane is one byte plus one parity bit, and a lane is written when its own enable is set and the byte-write master enable is on. A global write stores every lane whatever the lane enables are. The output enable gates the read data. When the output enable is off, the data bus reads zero and the drive flag is low.

Top module: `fts_burst_ram`

## Requirements
- R1: After reset the block is deselected, so `rd_drive` is 0 and `rd_data` is 0 even when `out_en` is 1.
- R2: On a rising edge where `addr_ld_ctl` is 1, or `addr_ld_cpu` is 1 while `chip_en` is 1, the block captures `addr` as the burst start and `chip_en` as its selected state, and it clears the beat counter. A controller strobe with `chip_en` at 0 deselects the block.
- R3: The beat counter steps by one (modulo 4) on an edge where `burst_step` is 1 and no strobe loads an address. With `burst_step` at 0 the counter holds. A loading strobe takes priority over `burst_step`.
- R4: `addr_ld_cpu` with `chip_en` at 0 and `addr_ld_ctl` at 0 leaves the burst state unchanged.
- R5: With `order_sel` at 0 (linear order), the word address is the upper start bits joined to (start[1:0] + beat) mod 4. The burst wraps inside its aligned group of four.
- R6: With `order_sel` at 1 (interleaved order), the low two address bits are start[1:0] XOR beat. `order_sel` acts without a clock edge.
- R7: While selected and `out_en` is 1, `rd_data` shows the stored word at the current burst address combinationally and `rd_drive` is 1. Otherwise `rd_data` is 0 and `rd_drive` is 0. `out_en` acts without a clock edge. Lane i occupies bits [9i+8:9i], and bit 9i+8 is its parity bit.
- R8: On an edge where the block is selected, `wr_global` is 0 and `wr_byte_master` is 1, lane i is written exactly when `wr_byte_sel[i]` is 1. When both `wr_global` and `wr_byte_master` are 0, the edge writes nothing.
- R9: On an edge where the block is selected and `wr_global` is 1, all lanes are written regardless of `wr_byte_master` and `wr_byte_sel`.
- R10: Write inputs have no effect while the block is deselected.
- R11: A write on an edge goes to the burst address current before that edge, even when a strobe or step on the same edge changes the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of burst state |
| addr | input | AW | Word address captured by a strobe |
| chip_en | input | 1 | Chip enable captured by a strobe |
| addr_ld_cpu | input | 1 | Processor-side address strobe, honoured only with chip_en |
| addr_ld_ctl | input | 1 | Controller-side address strobe, always honoured |
| burst_step | input | 1 | Advance the beat counter |
| wr_global | input | 1 | Write all lanes |
| wr_byte_master | input | 1 | Master enable for per-lane writes |
| wr_byte_sel | input | NBYTES | Per-lane write enables |
| wdata | input | NBYTES*(BYTE_W+1) | Write data, byte plus parity per lane |
| out_en | input | 1 | Output enable, asynchronous |
| order_sel | input | 1 | 0 linear, 1 interleaved beat order, asynchronous |
| rd_data | output | NBYTES*(BYTE_W+1) | Flow-through read data, zero when not driven |
| rd_drive | output | 1 | High when the read data is driven |

## Verification
The bound checker checks the burst state on every cycle. It checks how a strobe loads the address, selection and counter, that a processor strobe is ignored while the chip is disabled, how the counter steps or holds, and that read data is forced to zero when the output enable is off. Only the bench scenarios can show the stored contents. These include per-lane and global writes, writes that do nothing while deselected, a write that lands on the old address when a strobe arrives on the same edge, and the two beat orders with their wrap. The bench also changes the order pin and output enable between edges, which shows their asynchronous effect.

// File: rtl/fts_pkg.sv
package fts_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Low address bits of a beat within its aligned group of four
    function automatic beat_t beat_offset(input beat_t start, input beat_t cnt, input order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ cnt;
        else                       r = beat_t'(start + cnt);
        return r;
    endfunction
endpackage

// File: rtl/fts_burst_ctl.sv
module fts_burst_ctl
    import fts_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          chip_en,
    input  logic          addr_ld_cpu,
    input  logic          addr_ld_ctl,
    input  logic          burst_step,
    output logic          sel_q,
    output logic [AW-1:0] base_q,
    output beat_t         cnt_q
);
    typedef struct packed {
        logic          sel;
        logic [AW-1:0] base;
        beat_t         cnt;
    } ctl_t;

    ctl_t s_d, s_q;
    logic load_d;

    always_comb begin
        s_d    = s_q;
        load_d = addr_ld_ctl || (addr_ld_cpu && chip_en);
        if (load_d) begin
            s_d.sel  = chip_en;
            s_d.base = addr;
            s_d.cnt  = '0;
        end else if (burst_step) begin
            s_d.cnt = beat_t'(s_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel_q  = s_q.sel;
    assign base_q = s_q.base;
    assign cnt_q  = s_q.cnt;
endmodule

// File: rtl/fts_addr_seq.sv
module fts_addr_seq
    import fts_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0] base,
    input  beat_t         cnt,
    input  logic          order_sel,
    output logic [AW-1:0] word_addr
);
    localparam int HI_W = AW - BEAT_W;

    logic [HI_W-1:0] hi;
    beat_t           lo;

    always_comb begin
        hi        = base[AW-1:BEAT_W];
        lo        = beat_offset(base[BEAT_W-1:0], cnt, order_e'(order_sel));
        word_addr = {hi, lo};
    end
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
    parameter int AW = 6,
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] wdata,
    output logic [LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int AW     = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [AW-1:0]                  addr,
    input  logic                           chip_en,
    input  logic                           addr_ld_cpu,
    input  logic                           addr_ld_ctl,
    input  logic                           burst_step,
    input  logic                           wr_global,
    input  logic                           wr_byte_master,
    input  logic [NBYTES-1:0]              wr_byte_sel,
    input  logic [NBYTES*(BYTE_W+1)-1:0]   wdata,
    input  logic                           out_en,
    input  logic                           order_sel,
    output logic [NBYTES*(BYTE_W+1)-1:0]   rd_data,
    output logic                           rd_drive
);
    localparam int LANE_W = BYTE_W + 1;
    localparam int DW     = NBYTES * LANE_W;

    logic          sel_q;
    logic [AW-1:0] base_q;
    beat_t         cnt_q;
    logic [AW-1:0] word_addr;
    logic [NBYTES-1:0] lane_we;
    logic [DW-1:0] rd_word;

    fts_burst_ctl #(.AW(AW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .chip_en     (chip_en),
        .addr_ld_cpu (addr_ld_cpu),
        .addr_ld_ctl (addr_ld_ctl),
        .burst_step  (burst_step),
        .sel_q       (sel_q),
        .base_q      (base_q),
        .cnt_q       (cnt_q)
    );

    fts_addr_seq #(.AW(AW)) u_seq (
        .base      (base_q),
        .cnt       (cnt_q),
        .order_sel (order_sel),
        .word_addr (word_addr)
    );

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_we[g] = sel_q && (wr_global || (wr_byte_master && wr_byte_sel[g]));

        fts_lane_array #(.AW(AW), .LW(LANE_W)) u_lane (
            .clk   (clk),
            .we    (lane_we[g]),
            .addr  (word_addr),
            .wdata (wdata[g*LANE_W +: LANE_W]),
            .rdata (rd_word[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        rd_drive = out_en && sel_q;
        rd_data  = rd_drive ? rd_word : '0;
    end
endmodule

module fts_burst_ram_chk #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          chip_en,
    input logic          addr_ld_cpu,
    input logic          addr_ld_ctl,
    input logic          burst_step,
    input logic          out_en,
    input logic          sel_q,
    input logic [AW-1:0] base_q,
    input logic [1:0]    cnt_q,
    input logic [DW-1:0] rd_data,
    input logic          rd_drive
);
    a_r2_strobe_load: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld_ctl || (addr_ld_cpu && chip_en)) |=>
            (base_q == $past(addr)) && (cnt_q == 2'd0) && (sel_q == $past(chip_en)));

    a_r4_cpu_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld_cpu && !chip_en && !addr_ld_ctl && !burst_step) |=>
            $stable(base_q) && $stable(cnt_q) && $stable(sel_q));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld_ctl && !(addr_ld_cpu && chip_en) && burst_step) |=>
            (cnt_q == 2'($past(cnt_q) + 2'd1)) && $stable(base_q) && $stable(sel_q));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld_ctl && !(addr_ld_cpu && chip_en) && !burst_step) |=>
            $stable(cnt_q) && $stable(base_q) && $stable(sel_q));

    a_r7_output_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!rd_drive && (rd_data == '0)));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .chip_en     (chip_en),
    .addr_ld_cpu (addr_ld_cpu),
    .addr_ld_ctl (addr_ld_ctl),
    .burst_step  (burst_step),
    .out_en      (out_en),
    .sel_q       (sel_q),
    .base_q      (base_q),
    .cnt_q       (cnt_q),
    .rd_data     (rd_data),
    .rd_drive    (rd_drive)
);

// File: tb/fts_burst_ram_tb.sv
module fts_burst_ram_tb;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int LW = 9;
    localparam int DW = NB * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic chip_en = 1'b0, addr_ld_cpu = 1'b0, addr_ld_ctl = 1'b0, burst_step = 1'b0;
    logic wr_global = 1'b0, wr_byte_master = 1'b0;
    logic [NB-1:0] wr_byte_sel = '0;
    logic [DW-1:0] wdata = '0;
    logic out_en = 1'b1, order_sel = 1'b0;
    logic [DW-1:0] rd_data;
    logic rd_drive;

    always #5 clk = ~clk;

    fts_burst_ram #(.AW(AW), .NBYTES(NB), .BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en(chip_en),
        .addr_ld_cpu(addr_ld_cpu), .addr_ld_ctl(addr_ld_ctl), .burst_step(burst_step),
        .wr_global(wr_global), .wr_byte_master(wr_byte_master), .wr_byte_sel(wr_byte_sel),
        .wdata(wdata), .out_en(out_en), .order_sel(order_sel),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    logic [DW-1:0] ref_mem [1 << AW];
    logic          m_sel = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    logic [DW:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = order_sel ? (m_base[1:0] ^ m_cnt) : 2'(m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW:0] m_expect();
        logic en;
        en = out_en && m_sel;
        return {en, en ? ref_mem[m_addr()] : {DW{1'b0}}};
    endfunction

    function automatic logic [DW-1:0] pat(input int k);
        return {9'(9'h100 | 9'(k * 4 + 3)), 9'(k * 4 + 2), 9'(k * 4 + 1), 9'(k * 4)};
    endfunction

    task automatic check(input string tag, input logic [DW:0] e);
        checks++;
        if (rd_data !== e[DW-1:0] || rd_drive !== e[DW]) begin
            fails++;
            $display("FAIL %s rd_data=%h rd_drive=%b expected rd_data=%h rd_drive=%b",
                     tag, rd_data, rd_drive, e[DW-1:0], e[DW]);
        end
    endtask

    // monitor: compares queued expectations shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
        end
    end

    // driver: one clock cycle of stimulus, model update, expectation push
    task automatic tick(input logic p, input logic c, input logic ce, input logic st,
                        input logic gw, input logic bm, input logic [NB-1:0] bs,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        logic [AW-1:0] wa;
        addr_ld_cpu = p; addr_ld_ctl = c; chip_en = ce; burst_step = st;
        wr_global = gw; wr_byte_master = bm; wr_byte_sel = bs; addr = a; wdata = wd;
        @(posedge clk);
        wa = m_addr();
        if (m_sel) begin
            for (int i = 0; i < NB; i++)
                if (gw || (bm && bs[i])) ref_mem[wa][i*LW +: LW] = wd[i*LW +: LW];
        end
        if (c || (p && ce)) begin
            m_sel = ce; m_base = a; m_cnt = 2'd0;
        end else if (st) begin
            m_cnt = 2'(m_cnt + 2'd1);
        end
        exp_q.push_back(m_expect());
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic start_ctl(input logic [AW-1:0] a, input logic ce, input string tag);
        tick(1'b0, 1'b1, ce, 1'b0, 1'b0, 1'b0, '0, a, '0, tag);
    endtask

    task automatic start_cpu(input logic [AW-1:0] a, input string tag);
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, a, '0, tag);
    endtask

    task automatic step(input logic st, input string tag);
        tick(1'b0, 1'b0, 1'b1, st, 1'b0, 1'b0, '0, '0, '0, tag);
    endtask

    task automatic wr(input logic gw, input logic bm, input logic [NB-1:0] bs,
                      input logic [DW-1:0] wd, input logic st, input string tag);
        tick(1'b0, 1'b0, 1'b1, st, gw, bm, bs, '0, wd, tag);
    endtask

    task automatic async_chk(input string tag);
        #1;
        check(tag, m_expect());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired rd_data=%h expected completion", rd_data);
        finish_run();
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 'x;
        repeat (3) @(negedge clk);
        async_chk("R1");
        rst_n = 1'b1;
        @(negedge clk);
        async_chk("R1");

        // fill group 8..11 with global writes while stepping (R9, R5 wrap)
        start_ctl(6'd8, 1'b1, "R2");
        for (int k = 0; k < 4; k++) wr(1'b1, 1'b0, '0, pat(k), 1'b1, "R9");
        // fill group 20..23
        start_ctl(6'd20, 1'b1, "R2");
        for (int k = 4; k < 8; k++) wr(1'b1, 1'b0, '0, pat(k), 1'b1, "R9");

        // linear burst from 10: 10,11,8,9 then wrap to 10
        start_cpu(6'd10, "R2");
        for (int k = 0; k < 4; k++) step(1'b1, "R5");
        step(1'b0, "R3");

        // interleaved burst from 9: 9,8,11,10 then wrap to 9
        order_sel = 1'b1;
        start_cpu(6'd9, "R6");
        for (int k = 0; k < 4; k++) step(1'b1, "R6");
        step(1'b1, "R6");                 // beat 1: 8 interleaved
        order_sel = 1'b0;
        async_chk("R6");                  // linear beat 1: 10
        order_sel = 1'b1;
        async_chk("R6");
        order_sel = 1'b0;

        // per-lane write and no-write cycle at address 8
        start_ctl(6'd8, 1'b1, "R2");
        wr(1'b0, 1'b1, 4'b0101, {DW{1'b1}}, 1'b0, "R8");
        wr(1'b0, 1'b0, 4'b1111, '0, 1'b0, "R8");
        wr(1'b0, 1'b1, 4'b1010, 36'h0_0000_0000, 1'b0, "R8");
        // global write overrides master and lane enables
        wr(1'b1, 1'b0, 4'b0000, 36'h9_8765_4321, 1'b0, "R9");

        // write on strobe edge goes to old address 21
        start_ctl(6'd20, 1'b1, "R2");
        step(1'b1, "R5");
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 6'd8, 36'hA_AAAA_5555, "R11");
        start_ctl(6'd21, 1'b1, "R11");

        // cpu strobe ignored while chip disabled
        start_ctl(6'd20, 1'b1, "R2");
        step(1'b1, "R5");
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 6'd0, '0, "R4");
        step(1'b1, "R4");

        // strobe wins over step on the same edge
        tick(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, 6'd22, '0, "R3");
        step(1'b0, "R3");
        step(1'b1, "R3");

        // deselect, writes ignored, then reselect and read back
        start_ctl(6'd8, 1'b0, "R2");
        wr(1'b1, 1'b1, 4'b1111, 36'h0_0000_0000, 1'b0, "R10");
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, 6'd9, '0, "R10");
        start_ctl(6'd8, 1'b1, "R10");

        // output enable gating
        out_en = 1'b0;
        async_chk("R7");
        step(1'b1, "R7");
        out_en = 1'b1;
        async_chk("R7");
        step(1'b1, "R7");

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule